// File: doc/BRIEF.md
# Chip-Select-Timed Multiplexed Bus Demultiplexer

This block recovers write transfers from a host's multiplexed parallel bus when the host provides no address-latch strobe. Address and data share one set of pins. The active-low chip select acts as the phase marker. While select is inactive, the pins carry an address. The address of a transfer is the pin value that was registered one rising edge before select is first seen low. The data word is taken from the low pin lanes on the edge after that.

All inputs are sampled on the rising edge of the bus clock, and all logic runs in that clock domain. Each accepted transfer appears on the internal side as a single-cycle write strobe, with the recovered address and data word valid alongside it. The scheme has tight setup and hold margins on the shared pins, so it is meant for low bus clock rates.

Top module: `csbus_demux`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, `wr_stb`, `wr_addr` and `wr_data` are cleared to zero on the following edge.
- R2: The reported address is the full 24-bit `bus_ad` value sampled at the rising edge immediately before the edge where `bus_cs_n` is first seen low. The pin value at the select-low edge itself is not used.
- R3: The reported data is `bus_ad[15:0]`, sampled at the rising edge after the select-low edge. `bus_ad[23:16]` has no effect on the data word.
- R4: `wr_stb` goes high for exactly one clock cycle, starting right after the data edge. `wr_addr` and `wr_data` take their new values in that same cycle.
- R5: Only one strobe is issued per low period of `bus_cs_n`. Holding select low for further cycles produces no further strobes.
- R6: If `bus_cs_n` is seen high at the data edge, the transfer is dropped. No strobe is issued and the outputs keep their previous values.
- R7: Transfers whose select-high gap is a single cycle are each captured, with their own address and data.
- R8: `wr_addr` and `wr_data` change only in a cycle where `wr_stb` is high.
- R9: After reset, no transfer starts until `bus_cs_n` has been seen high on at least one edge. A select that is already low when reset is released is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; every register uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs_n | input | 1 | Active-low chip select from the host |
| bus_ad | input | 24 | Shared address/data pins |
| wr_stb | output | 1 | Single-cycle write strobe to internal logic |
| wr_addr | output | 24 | Recovered address, valid with `wr_stb` |
| wr_data | output | 16 | Captured write data, valid with `wr_stb` |

## Verification
Call the edge where select is first seen low edge k. The address comes from the pin sample at edge k-1, the data from the pins at edge k+1, and the strobe is visible between edge k+1 and edge k+2. Both the strobe and the outputs are registered, so the bench drives the pins on falling clock edges and reads the result at the falling edge that follows edge k+1. A strobe counter is updated one nanosecond after each rising edge, and the drop and reset cases compare this counter before and after the stimulus. The bound checker uses three-cycle `$past` windows to tie each strobe back to the pin and select history that produced it.

// File: rtl/csbus_pkg.sv
package csbus_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;

endpackage

// File: rtl/csbus_pin_sampler.sv
module csbus_pin_sampler #(
    parameter int PIN_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_cs_n,
    input  logic [PIN_W-1:0] pin_ad,
    output logic [PIN_W-1:0] prev_ad,
    output logic             cs_fall
);

    typedef struct packed {
        logic [PIN_W-1:0] ad;
        logic             cs_n;
    } smp_t;

    smp_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.ad   = pin_ad;
        s_d.cs_n = pin_cs_n;
    end

    // Reset leaves the select copy "low" so that a select held low
    // through reset is never taken as a fresh falling edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign prev_ad = s_q.ad;
    assign cs_fall = s_q.cs_n & ~pin_cs_n;

endmodule

// File: rtl/csbus_phase_ctrl.sv
module csbus_phase_ctrl
    import csbus_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              cs_fall,
    input  logic [ADDR_W-1:0] prev_ad,
    input  logic [DATA_W-1:0] live_data,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] addr_pend;
        logic [ADDR_W-1:0] addr_out;
        logic [DATA_W-1:0] data_out;
        logic              stb;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.stb = 1'b0;
        unique case (c_q.phase)
            PH_IDLE: begin
                if (cs_fall) begin
                    c_d.addr_pend = prev_ad;
                    c_d.phase     = PH_DATA;
                end
            end
            PH_DATA: begin
                if (cs_n) begin
                    c_d.phase = PH_IDLE;
                end else begin
                    c_d.addr_out = c_q.addr_pend;
                    c_d.data_out = live_data;
                    c_d.stb      = 1'b1;
                    c_d.phase    = PH_HOLD;
                end
            end
            PH_HOLD: begin
                if (cs_n) begin
                    c_d.phase = PH_IDLE;
                end
            end
            default: begin
                c_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q       <= '0;
            c_q.phase <= PH_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign wr_stb  = c_q.stb;
    assign wr_addr = c_q.addr_out;
    assign wr_data = c_q.data_out;

endmodule

// File: rtl/csbus_demux.sv
module csbus_demux #(
    parameter int PIN_W  = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_cs_n,
    input  logic [PIN_W-1:0]  bus_ad,
    output logic              wr_stb,
    output logic [PIN_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int ADDR_W = PIN_W;

    logic [ADDR_W-1:0] prev_ad;
    logic              cs_fall;

    csbus_pin_sampler #(
        .PIN_W (PIN_W)
    ) u_sampler (
        .clk      (clk),
        .rst      (rst),
        .pin_cs_n (bus_cs_n),
        .pin_ad   (bus_ad),
        .prev_ad  (prev_ad),
        .cs_fall  (cs_fall)
    );

    csbus_phase_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (bus_cs_n),
        .cs_fall   (cs_fall),
        .prev_ad   (prev_ad),
        .live_data (bus_ad[DATA_W-1:0]),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

endmodule

// File: rtl/csbus_demux_chk.sv
module csbus_demux_chk #(
    parameter int PIN_W  = 24,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_cs_n,
    input logic [PIN_W-1:0]  bus_ad,
    input logic              wr_stb,
    input logic [PIN_W-1:0]  wr_addr,
    input logic [DATA_W-1:0] wr_data
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!wr_stb && wr_addr == '0 && wr_data == '0));

    // R2
    addr_from_prior_edge_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> (wr_addr == $past(bus_ad, 3)));

    // R3
    data_low_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> (wr_data == $past(bus_ad[DATA_W-1:0], 1)));

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R6
    select_history_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> ($past(bus_cs_n, 3) && !$past(bus_cs_n, 2) && !$past(bus_cs_n, 1)));

    // R8
    outputs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |-> ($stable(wr_addr) && $stable(wr_data)));

endmodule

bind csbus_demux csbus_demux_chk #(
    .PIN_W  (PIN_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_cs_n (bus_cs_n),
    .bus_ad   (bus_ad),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
);

// File: tb/csbus_demux_bench.sv
module csbus_demux_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic [23:0] ad = '0;
    logic        wr_stb;
    logic [23:0] wr_addr;
    logic [15:0] wr_data;

    int total = 0;
    int bad = 0;
    int stb_seen = 0;
    bit finished = 1'b0;

    csbus_demux u_csbus_demux (
        .clk      (clk),
        .rst      (rst),
        .bus_cs_n (cs_n),
        .bus_ad   (ad),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        #1;
        if (!rst && wr_stb) stb_seen++;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        logic [23:0] la;
        logic [15:0] ld;
        la = wr_addr;
        ld = wr_data;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cs_n = 1'b1;
            ad = 24'h00F00D + 24'(i);
            chk(wr_stb == 1'b0, "R8 idle strobe", 32'(wr_stb), 0);
            chk(wr_addr == la && wr_data == ld, "R8 idle hold", {8'h0, wr_addr}, {8'h0, la});
        end
    endtask

    // One write; pre: select-high/address already driven; chain: drive next address
    task automatic xfer(input logic [23:0] a, input logic [15:0] d, input bit pre,
                        input bit chain, input logic [23:0] next_a, input int hold);
        logic [23:0] la;
        logic [15:0] ld;
        if (!pre) begin
            @(negedge clk);
            cs_n = 1'b1;
            ad = a;
        end
        @(negedge clk);
        chk(wr_stb == 1'b0, "R4 no early strobe", 32'(wr_stb), 0);
        cs_n = 1'b0;
        ad = ~a;
        @(negedge clk);
        chk(wr_stb == 1'b0, "R4 no early strobe", 32'(wr_stb), 0);
        cs_n = 1'b0;
        ad = {8'hA5, d};
        @(negedge clk);
        chk(wr_stb == 1'b1, "R4 strobe", 32'(wr_stb), 1);
        chk(wr_addr == a, "R2 address", {8'h0, wr_addr}, {8'h0, a});
        chk(wr_data == d, "R3 data", {16'h0, wr_data}, {16'h0, d});
        la = wr_addr;
        ld = wr_data;
        if (chain) begin
            cs_n = 1'b1;
            ad = next_a;
        end else begin
            cs_n = 1'b0;
            ad = 24'h5A5A5A;
            for (int i = 0; i < hold; i++) begin
                @(negedge clk);
                ad = 24'h3C3C00 + 24'(i);
                chk(wr_stb == 1'b0, "R5 held select", 32'(wr_stb), 0);
                chk(wr_addr == la && wr_data == ld, "R8 held outputs", {8'h0, wr_addr}, {8'h0, la});
            end
            cs_n = 1'b1;
            ad = '0;
        end
    endtask

    task automatic t_basic;
        int s0;
        s0 = stb_seen;
        xfer(24'h000001, 16'h1234, 0, 0, 0, 0);
        idle(3);
        xfer(24'hFFFFFE, 16'hBEEF, 0, 0, 0, 0);
        idle(1);
        xfer(24'h800000, 16'h0000, 0, 0, 0, 0);
        idle(2);
        chk(stb_seen - s0 == 3, "R4 strobe count", 32'(stb_seen - s0), 3);
    endtask

    task automatic t_hold;
        int s0;
        s0 = stb_seen;
        xfer(24'h13579B, 16'hFFFF, 0, 0, 0, 6);
        idle(2);
        chk(stb_seen - s0 == 1, "R5 one strobe per low period", 32'(stb_seen - s0), 1);
    endtask

    task automatic t_abort;
        int s0;
        logic [23:0] la;
        logic [15:0] ld;
        s0 = stb_seen;
        la = wr_addr;
        ld = wr_data;
        @(negedge clk); cs_n = 1'b1; ad = 24'hDEAD00;
        @(negedge clk); cs_n = 1'b0; ad = 24'h111111;
        @(negedge clk); cs_n = 1'b1; ad = 24'h00C0DE;
        @(negedge clk); cs_n = 1'b1; ad = 24'h222222;
        @(negedge clk);
        chk(stb_seen == s0, "R6 dropped transfer", 32'(stb_seen - s0), 0);
        chk(wr_addr == la && wr_data == ld, "R6 outputs kept", {8'h0, wr_addr}, {8'h0, la});
        // drop followed at once by a good transfer
        cs_n = 1'b1; ad = 24'h0000AA;
        @(negedge clk); cs_n = 1'b0; ad = 24'h333333;
        @(negedge clk); cs_n = 1'b1; ad = 24'h0ABCDE;
        xfer(24'h0ABCDE, 16'h7E57, 1, 0, 0, 0);
        idle(2);
        chk(stb_seen - s0 == 1, "R6 only the good transfer", 32'(stb_seen - s0), 1);
    endtask

    task automatic t_b2b;
        int s0;
        s0 = stb_seen;
        xfer(24'hA00001, 16'h0101, 0, 1, 24'hA00002, 0);
        xfer(24'hA00002, 16'h0202, 1, 1, 24'hA00003, 0);
        xfer(24'hA00003, 16'h0303, 1, 0, 0, 0);
        idle(2);
        chk(stb_seen - s0 == 3, "R7 back-to-back count", 32'(stb_seen - s0), 3);
    endtask

    task automatic t_reset_low;
        int s0;
        @(negedge clk); rst = 1'b1; cs_n = 1'b0; ad = 24'h123456;
        @(negedge clk);
        @(negedge clk);
        chk(wr_stb == 1'b0 && wr_addr == '0 && wr_data == '0, "R1 reset clears",
            {8'h0, wr_addr}, 0);
        s0 = stb_seen;
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            ad = 24'h654320 + 24'(i);
        end
        @(negedge clk);
        chk(stb_seen == s0, "R9 select low at reset release", 32'(stb_seen - s0), 0);
        chk(wr_addr == '0, "R9 address untouched", {8'h0, wr_addr}, 0);
        cs_n = 1'b1; ad = '0;
        xfer(24'h0FACE0, 16'hCAFE, 0, 0, 0, 1);
        idle(1);
    endtask

    initial begin
        rst = 1'b1;
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(wr_stb == 1'b0 && wr_addr == '0 && wr_data == '0, "R1 reset state",
            {8'h0, wr_addr}, 0);
        rst = 1'b0;
        idle(2);
        t_basic;
        t_hold;
        t_abort;
        t_b2b;
        t_reset_low;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule